// File: doc/BRIEF.md
# Accumulator Addressing-Mode Microsequencer

This block is an 8-bit accumulator datapath driven by a micro-operation sequencer. It holds a program counter, an opcode register, a temporary address register and an index register, and it executes add-to-accumulator instructions in four operand modes. The modes are an operand byte taken from the instruction, a zero-page address, a full 16-bit address, and an index plus an unsigned offset. It also executes an instruction that clears the accumulator.

Each micro-operation performs at most one memory read. The memory returns `mem_rdata` for the `mem_addr` of the current cycle, and the block captures it on the clock edge that ends that cycle. The index register is written through a load port. A one-cycle `done` pulse marks the last cycle of every instruction, so the length of each instruction can be measured from outside.

Top module: `acc_mode_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block sets `pc_q` to parameter RESET_PC (default 0x0100) and clears `acc_q`, `x_q` and `flags_q`. `done` is low while `rst` is high.
- R2: The first cycle of every instruction reads the opcode at `pc_q` and increments `pc_q`. Each further instruction byte that is read also increments `pc_q` by one.
- R3: Opcode 0x8B (operand in instruction) adds the following byte to the accumulator. It takes 2 cycles and advances `pc_q` by 2.
- R4: Opcode 0x9B (zero page) reads its operand at address {0x00, next byte}. The high address byte is zero even when an earlier instruction left a non-zero value in the temporary register. It takes 3 cycles and advances `pc_q` by 2.
- R5: Opcode 0xBB (absolute) takes the next two bytes as the operand address, high byte first. It takes 4 cycles and advances `pc_q` by 3.
- R6: Opcode 0xAB (indexed) reads its operand at `x_q` plus the zero-extended offset byte, modulo 2^16. It takes 4 cycles and advances `pc_q` by 2.
- R7: Opcode 0x4F writes 0 to the accumulator and sets `flags_q` to 4'b0100. It takes 2 cycles and advances `pc_q` by 1.
- R8: After an add, `flags_q` holds {N,Z,V,C} in bits 3..0. N is bit 7 of the result. Z is set when the result is zero. V is set when both addends have the same sign and the result has the other sign. C is the carry out of bit 7.
- R9: Any other opcode takes 1 cycle, advances `pc_q` by 1 and leaves the accumulator and the flags unchanged.
- R10: `done` is high in exactly the last cycle of each instruction.
- R11: When `x_ld` is high at a rising edge, `x_q` takes the value of `x_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory read address for this cycle |
| mem_rdata | input | 8 | Byte at `mem_addr` |
| x_ld | input | 1 | Index register write enable |
| x_din | input | 16 | Index register write value |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 4 | {N,Z,V,C} |
| pc_q | output | 16 | Program counter |
| x_q | output | 16 | Index register |
| done | output | 1 | Last cycle of an instruction |

## Verification
Each instruction's result is compared against a model, together with its flags, its final program counter and its length in cycles. An absolute-mode read leaves a high address byte in the temporary register, and a zero-page read follows it; a wrong byte at the stale address shows whether the high byte is cleared. Operand pairs are chosen to set signed overflow alone, carry with zero, and carry without overflow, which separates the V rule from the C rule. Indexed reads use an index near the top of memory with offsets of 0x20 and 0xF0, so a missing wrap or a sign-extended offset reads a planted wrong byte.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   localparam logic [7:0] OP_ADD_IMM = 8'h8B;
   localparam logic [7:0] OP_ADD_ZPG = 8'h9B;
   localparam logic [7:0] OP_ADD_ABS = 8'hBB;
   localparam logic [7:0] OP_ADD_IDX = 8'hAB;
   localparam logic [7:0] OP_CLR_ACC = 8'h4F;

   typedef enum logic [3:0] {
      ST_FETCH,
      ST_IMM,
      ST_ZLO,
      ST_AHI,
      ST_ALO,
      ST_OFS,
      ST_XADD,
      ST_OPND,
      ST_CLR
   } seq_st_t;

   typedef enum logic [1:0] {
      ACC_HOLD,
      ACC_ADD,
      ACC_CLR
   } acc_op_t;

   typedef enum logic [2:0] {
      T_HOLD,
      T_ZEXT,
      T_HIGH,
      T_LOW,
      T_INDEX
   } tmp_op_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] rdata,
   output seq_st_t           st,
   output acc_op_t           acc_op,
   output tmp_op_t           tmp_op,
   output logic              pc_inc,
   output logic              use_tmp,
   output logic              done
);

   seq_st_t           st_n;
   logic [DATA_W-1:0] opc_q;
   logic              done_c;

   always_comb begin
      st_n    = st;
      acc_op  = ACC_HOLD;
      tmp_op  = T_HOLD;
      pc_inc  = 1'b0;
      use_tmp = 1'b0;
      done_c  = 1'b0;
      case (st)
         ST_FETCH: begin
            pc_inc = 1'b1;
            case (rdata)
               OP_ADD_IMM: st_n = ST_IMM;
               OP_ADD_ZPG: st_n = ST_ZLO;
               OP_ADD_ABS: st_n = ST_AHI;
               OP_ADD_IDX: st_n = ST_OFS;
               OP_CLR_ACC: st_n = ST_CLR;
               default: begin
                  st_n   = ST_FETCH;
                  done_c = 1'b1;
               end
            endcase
         end
         ST_IMM: begin
            pc_inc = 1'b1;
            acc_op = ACC_ADD;
            done_c = 1'b1;
            st_n   = ST_FETCH;
         end
         ST_ZLO: begin
            pc_inc = 1'b1;
            tmp_op = T_ZEXT;
            st_n   = ST_OPND;
         end
         ST_AHI: begin
            pc_inc = 1'b1;
            tmp_op = T_HIGH;
            st_n   = ST_ALO;
         end
         ST_ALO: begin
            pc_inc = 1'b1;
            tmp_op = T_LOW;
            st_n   = ST_OPND;
         end
         ST_OFS: begin
            pc_inc = 1'b1;
            tmp_op = T_ZEXT;
            st_n   = ST_XADD;
         end
         ST_XADD: begin
            tmp_op = T_INDEX;
            st_n   = ST_OPND;
         end
         ST_OPND: begin
            use_tmp = 1'b1;
            acc_op  = ACC_ADD;
            done_c  = 1'b1;
            st_n    = ST_FETCH;
         end
         ST_CLR: begin
            acc_op = ACC_CLR;
            done_c = 1'b1;
            st_n   = ST_FETCH;
         end
         default: st_n = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_FETCH;
         opc_q <= '0;
      end else begin
         st <= st_n;
         if (st == ST_FETCH) opc_q <= rdata;
      end
   end

   assign done = done_c & ~rst;

   // R10: an instruction always ends with a return to opcode fetch
   p_done_refetch_r10: assert property (@(posedge clk) disable iff (rst)
      done |=> st == ST_FETCH);

   // R9: an unknown opcode finishes in the fetch cycle itself
   p_undef_single_r9: assert property (@(posedge clk) disable iff (rst)
      (st == ST_FETCH && done) |=> st == ST_FETCH);

   // R4: operand reads only happen for the three memory modes
   p_opnd_mode_r4: assert property (@(posedge clk) disable iff (rst)
      st == ST_OPND |-> (opc_q == OP_ADD_ZPG || opc_q == OP_ADD_ABS || opc_q == OP_ADD_IDX));

   // R6: the index addition is always followed by the operand read
   p_index_then_read_r6: assert property (@(posedge clk) disable iff (rst)
      st == ST_XADD |=> st == ST_OPND);

endmodule

// File: rtl/acc_seq_agen.sv
module acc_seq_agen
   import acc_seq_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] RESET_PC = 16'h0100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] rdata,
   input  tmp_op_t           tmp_op,
   input  logic              pc_inc,
   input  logic              use_tmp,
   input  logic              x_ld,
   input  logic [ADDR_W-1:0] x_din,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] x
);

   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] tmp;
   logic [ADDR_W-1:0] tmp_n;

   always_comb begin
      tmp_n = tmp;
      case (tmp_op)
         T_ZEXT:  tmp_n = {{HI_W{1'b0}}, rdata};
         T_HIGH:  tmp_n = {rdata, tmp[DATA_W-1:0]};
         T_LOW:   tmp_n = {tmp[ADDR_W-1:DATA_W], rdata};
         T_INDEX: tmp_n = tmp + x;
         default: tmp_n = tmp;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= ADDR_W'(RESET_PC);
         tmp <= '0;
         x   <= '0;
      end else begin
         if (pc_inc) pc <= pc + 1'b1;
         tmp <= tmp_n;
         if (x_ld) x <= x_din;
      end
   end

   assign mem_addr = use_tmp ? tmp : pc;

   // R2: every consumed instruction byte moves the program counter by one
   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      pc_inc |=> pc == $past(pc) + 1'b1);

   // R4: a zero-page operand address never carries a high byte
   p_zpg_high_clear_r4: assert property (@(posedge clk) disable iff (rst)
      tmp_op == T_ZEXT |=> tmp[ADDR_W-1:DATA_W] == '0);

   // R11: index writes land one edge later
   p_x_load_r11: assert property (@(posedge clk) disable iff (rst)
      x_ld |=> x == $past(x_din));

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
   import acc_seq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit V_FROM_CARRY = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  acc_op_t           acc_op,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] acc,
   output flags_t            flags
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] sum;
   logic [DATA_W-1:0] res;
   logic            ovf;

   assign sum = {1'b0, acc} + {1'b0, rdata};
   assign res = sum[DATA_W-1:0];

   generate
      if (V_FROM_CARRY) begin : g_v_carry
         logic [MSB:0] low_sum;
         assign low_sum = {1'b0, acc[MSB-1:0]} + {1'b0, rdata[MSB-1:0]};
         assign ovf = low_sum[MSB] ^ sum[DATA_W];
      end else begin : g_v_sign
         assign ovf = (acc[MSB] == rdata[MSB]) && (res[MSB] != acc[MSB]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         acc   <= '0;
         flags <= '0;
      end else begin
         case (acc_op)
            ACC_ADD: begin
               acc     <= res;
               flags.n <= res[MSB];
               flags.z <= (res == '0);
               flags.v <= ovf;
               flags.c <= sum[DATA_W];
            end
            ACC_CLR: begin
               acc   <= '0;
               flags <= 4'b0100;
            end
            default: ;
         endcase
      end
   end

   // R7: clear leaves a zero accumulator and flags N=0 Z=1 V=0 C=0
   p_clear_result_r7: assert property (@(posedge clk) disable iff (rst)
      acc_op == ACC_CLR |=> (acc == '0 && flags == 4'b0100));

   // R8: sign and zero flags agree with the written accumulator
   p_nz_follow_r8: assert property (@(posedge clk) disable iff (rst)
      acc_op == ACC_ADD |=> (flags.n == acc[MSB] && flags.z == (acc == '0)));

   // R9: cycles without a write keep accumulator and flags
   p_hold_state_r9: assert property (@(posedge clk) disable iff (rst)
      acc_op == ACC_HOLD |=> ($stable(acc) && $stable(flags)));

endmodule

// File: rtl/acc_mode_seq.sv
module acc_mode_seq
   import acc_seq_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          ADDR_W       = 16,
   parameter logic [15:0] RESET_PC     = 16'h0100,
   parameter bit          V_FROM_CARRY = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              x_ld,
   input  logic [ADDR_W-1:0] x_din,
   output logic [DATA_W-1:0] acc_q,
   output logic [3:0]        flags_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] x_q,
   output logic              done
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("acc_mode_seq: opcodes are byte wide, DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("acc_mode_seq: absolute mode needs ADDR_W equal to two data bytes");
      end
   endgenerate

   seq_st_t st;
   acc_op_t acc_op;
   tmp_op_t tmp_op;
   logic    pc_inc;
   logic    use_tmp;
   flags_t  flags;

   acc_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .rdata   (mem_rdata),
      .st      (st),
      .acc_op  (acc_op),
      .tmp_op  (tmp_op),
      .pc_inc  (pc_inc),
      .use_tmp (use_tmp),
      .done    (done)
   );

   acc_seq_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_agen (
      .clk      (clk),
      .rst      (rst),
      .rdata    (mem_rdata),
      .tmp_op   (tmp_op),
      .pc_inc   (pc_inc),
      .use_tmp  (use_tmp),
      .x_ld     (x_ld),
      .x_din    (x_din),
      .mem_addr (mem_addr),
      .pc       (pc_q),
      .x        (x_q)
   );

   acc_seq_alu #(.DATA_W(DATA_W), .V_FROM_CARRY(V_FROM_CARRY)) u_alu (
      .clk    (clk),
      .rst    (rst),
      .acc_op (acc_op),
      .rdata  (mem_rdata),
      .acc    (acc_q),
      .flags  (flags)
   );

   assign flags_q = flags;

   // R3: the operand-in-instruction add always ends in its second cycle
   p_imm_two_cycles_r3: assert property (@(posedge clk) disable iff (rst)
      st == ST_IMM |-> done);

   // R1: reset returns the program counter to its start value
   p_reset_pc_r1: assert property (@(posedge clk)
      rst |=> pc_q == ADDR_W'(RESET_PC));

endmodule

// File: tb/sim_acc_mode_seq.sv
module sim_acc_mode_seq;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        x_ld;
   logic [15:0] x_din;
   logic [7:0]  acc_q;
   logic [3:0]  flags_q;
   logic [15:0] pc_q;
   logic [15:0] x_q;
   logic        done;

   always #4 clk = ~clk;

   logic [7:0] mem [0:2047];
   assign mem_rdata = mem[mem_addr[10:0]];

   acc_mode_seq u0 (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .x_ld      (x_ld),
      .x_din     (x_din),
      .acc_q     (acc_q),
      .flags_q   (flags_q),
      .pc_q      (pc_q),
      .x_q       (x_q),
      .done      (done)
   );

   typedef struct {
      logic [7:0]  acc;
      logic [3:0]  fl;
      logic [15:0] pc;
      int          len;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   int total = 0;
   int bad   = 0;

   logic [7:0]  m_acc;
   logic [3:0]  m_fl;
   logic [15:0] m_pc;
   logic [15:0] m_x;
   logic [15:0] wp;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      mem[wp[10:0]] = b;
      wp = wp + 16'd1;
   endtask

   task automatic model_add(input logic [7:0] b);
      logic [8:0] s;
      logic [7:0] r;
      s = {1'b0, m_acc} + {1'b0, b};
      r = s[7:0];
      m_fl = {r[7], (r == 8'h00), (m_acc[7] == b[7]) && (r[7] != m_acc[7]), s[8]};
      m_acc = r;
   endtask

   task automatic push(input int len, input string tag);
      exp_t e;
      e.acc = m_acc; e.fl = m_fl; e.pc = m_pc; e.len = len; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // driver tasks: lay down one instruction and queue its expected outcome
   task automatic i_imm(input logic [7:0] v);
      put(8'h8B); put(v);
      model_add(v); m_pc = m_pc + 16'd2; push(2, "R3");
   endtask

   task automatic i_zpg(input logic [7:0] dd, input logic [7:0] v);
      mem[{3'b000, dd}] = v;
      put(8'h9B); put(dd);
      model_add(v); m_pc = m_pc + 16'd2; push(3, "R4");
   endtask

   task automatic i_abs(input logic [15:0] a, input logic [7:0] v);
      mem[a[10:0]] = v;
      put(8'hBB); put(a[15:8]); put(a[7:0]);
      model_add(v); m_pc = m_pc + 16'd3; push(4, "R5");
   endtask

   task automatic i_idx(input logic [7:0] off, input logic [7:0] v);
      logic [15:0] ea;
      ea = m_x + {8'h00, off};
      mem[ea[10:0]] = v;
      put(8'hAB); put(off);
      model_add(v); m_pc = m_pc + 16'd2; push(4, "R6");
   endtask

   task automatic i_clr();
      put(8'h4F);
      m_acc = 8'h00; m_fl = 4'b0100; m_pc = m_pc + 16'd1; push(2, "R7");
   endtask

   task automatic i_undef(input logic [7:0] op);
      put(op);
      m_pc = m_pc + 16'd1; push(1, "R9");
   endtask

   // monitor: pops one expected item per finished instruction
   logic pend = 1'b0;
   int   pend_len = 0;
   int   cnt = 0;

   always @(negedge clk) begin
      if (rst) begin
         pend = 1'b0;
         cnt  = 0;
      end else begin
         if (pend && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "acc", {24'h0, acc_q}, {24'h0, e.acc});
            chk((e.tag == "R7" || e.tag == "R9") ? e.tag : "R8", "flags",
                {28'h0, flags_q}, {28'h0, e.fl});
            chk("R2", "pc", {16'h0, pc_q}, {16'h0, e.pc});
            chk("R10", "cycles", pend_len, e.len);
         end
         cnt++;
         if (done) begin
            pend     = 1'b1;
            pend_len = cnt;
            cnt      = 0;
         end else begin
            pend = 1'b0;
         end
      end
   end

   task automatic check_reset();
      @(negedge clk);
      chk("R1", "acc", {24'h0, acc_q}, 32'h0);
      chk("R1", "flags", {28'h0, flags_q}, 32'h0);
      chk("R1", "pc", {16'h0, pc_q}, 32'h0100);
      chk("R1", "x", {16'h0, x_q}, 32'h0);
      chk("R1", "done", {31'h0, done}, 32'h0);
   endtask

   task automatic start_run(input logic [15:0] xv);
      @(posedge clk); #1;
      rst   = 1'b0;
      x_ld  = 1'b1;
      x_din = xv;
      @(posedge clk); #1;
      x_ld  = 1'b0;
      @(negedge clk);
      chk("R11", "x", {16'h0, x_q}, {16'h0, xv});
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      rst   = 1'b1;
      x_ld  = 1'b0;
      x_din = 16'h0;
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

      // run 1: program at 0x0100, X = 0x0100
      wp = 16'h0100; m_pc = 16'h0100; m_acc = 8'h00; m_fl = 4'h0; m_x = 16'h0100;
      i_clr();
      i_imm(8'h12);
      i_imm(8'h33);       // 0x12 + 0x33 = 0x45
      i_clr();
      i_imm(8'h12);
      i_abs(16'h0433, 8'h10);   // 0x22, leaves 0x04 in the temp high byte
      i_zpg(8'h33, 8'h05);      // reads 0x0033, not 0x0433 -> 0x27
      i_imm(8'h59);       // 0x80: N and V, no carry
      i_imm(8'h80);       // 0x00: Z, V and C
      i_idx(8'h80, 8'h7F);      // 0x0100 + 0x80 = 0x0180
      i_undef(8'h01);
      i_imm(8'h01);       // 0x80
      i_clr();

      repeat (3) @(posedge clk);
      check_reset();
      start_run(16'h0100);

      // run 2: reset again, X near the top of memory
      @(posedge clk); #1;
      rst = 1'b1;
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
      wp = 16'h0100; m_pc = 16'h0100; m_acc = 8'h00; m_fl = 4'h0; m_x = 16'hFFF0;
      mem[11'h7E0] = 8'h55;      // would be read if the offset were sign extended
      i_idx(8'h20, 8'h3C);      // wraps to 0x0010
      i_idx(8'hF0, 8'h01);      // 0x00E0
      i_clr();
      i_imm(8'hFF);
      i_imm(8'h01);       // 0x00: Z and C without V
      i_undef(8'hFF);
      repeat (3) @(posedge clk);
      check_reset();
      start_run(16'hFFF0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule